// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block selects the address the fetch stage uses next in a 32-bit, five-stage RISC pipeline. It is purely combinational. It receives the current program counter, three decoded redirect flags (conditional branch, direct jump, register jump), the two register operands, the 16-bit immediate and the 26-bit jump target. It returns the next program counter together with a redirect flag, which the flush logic uses to squash wrong-path fetches.

The only conditional branch is branch-if-not-equal. It is taken when the two operands differ. A direct jump keeps the top region bits of the current PC and replaces the rest with the target field, which is scaled to a word address. A register jump loads the whole first operand. Every other case steps to the next sequential instruction. The operands are assumed to arrive already forwarded.

A small control module resolves the priority and emits a one-hot select struct. A datapath module builds the four candidate addresses and picks one with an AND-OR multiplexer.

Top module: `pc_steer`

## Requirements
- R1: With no redirect flag set, `nextPc` equals `curPc + 4` and `redirect` is 0.
- R2: With `isBranch` set and `opA != opB`, `nextPc` equals `curPc + 4 + (signExt(imm) << 2)` and `redirect` is 1.
- R3: With `isBranch` set and `opA == opB`, `nextPc` equals `curPc + 4` and `redirect` is 0.
- R4: The branch offset is sign-extended from `imm[15]`. When `imm[15]` is 1, the target lies below `curPc + 4`. For example, `imm = 16'h8000` moves back 0x20000 bytes.
- R5: With `isJump` set, `nextPc` equals `{curPc[31:28], jumpTarget[25:0], 2'b00}` and `redirect` is 1.
- R6: With `isJumpReg` set, `nextPc` equals all 32 bits of `opA`, unaligned values included, and `redirect` is 1.
- R7: When more than one flag is set, the register jump wins over the direct jump, and the direct jump wins over a taken branch.
- R8: All additions wrap modulo 2^32. No alignment or overflow fault is raised. For example, `curPc = 32'hFFFF_FFFC` with no flag gives `nextPc = 0`.
- R9: `redirect` is 1 exactly when a register jump, a direct jump or a taken branch is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| curPc | input | 32 | Address of the instruction being resolved |
| isBranch | input | 1 | Decoded branch-if-not-equal |
| isJump | input | 1 | Decoded direct jump |
| isJumpReg | input | 1 | Decoded register-indirect jump |
| opA | input | 32 | First register operand, forwarded |
| opB | input | 32 | Second register operand, forwarded |
| imm | input | 16 | Branch immediate, counted in instructions |
| jumpTarget | input | 26 | Direct jump target field, counted in words |
| nextPc | output | 32 | Selected next program counter |
| redirect | output | 1 | High when control flow leaves the sequential path |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit immediate, a 26-bit jump target and 4-byte instructions. These defaults leave a 4-bit region field. They also bring the two edge cases within reach: a step past the top of the address space, and a jump that keeps the region while changing every target bit. Directed vectors cover each redirect source, both signs of the offset, operand equality and every combination of overlapping flags. They are followed by pseudo-random vectors, each compared against a behavioural model.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;
  // One-hot choice of next-PC source, produced by the control module.
  typedef struct packed {
    logic takeReg;
    logic takeJump;
    logic takeBranch;
    logic takeSeq;
  } pcSel_t;
endpackage

// File: rtl/pc_steer_ctrl.sv
module pc_steer_ctrl
  import pc_steer_pkg::*;
(
  input  logic   isBranch,
  input  logic   isJump,
  input  logic   isJumpReg,
  input  logic   opsDiffer,
  output pcSel_t sel,
  output logic   redirect
);
  logic branchTaken;
  assign branchTaken = isBranch & opsDiffer;

  // Priority: register jump, direct jump, taken branch, sequential.
  always_comb begin
    sel = '0;
    if (isJumpReg)        sel.takeReg    = 1'b1;
    else if (isJump)      sel.takeJump   = 1'b1;
    else if (branchTaken) sel.takeBranch = 1'b1;
    else                  sel.takeSeq    = 1'b1;
  end

  assign redirect = isJumpReg | isJump | branchTaken;

  always_comb begin
    assert_sel_onehot_R7: assert ($onehot(sel))
      else $error("next-PC select not one-hot");
    assert_redirect_matches_R9: assert (redirect == !sel.takeSeq)
      else $error("redirect disagrees with sequential select");
    assert_equal_falls_through_R3: assert (!(isBranch && !opsDiffer && !isJump && !isJumpReg) || sel.takeSeq)
      else $error("branch on equal operands did not fall through");
  end
endmodule

// File: rtl/pc_steer_datapath.sv
module pc_steer_datapath
  import pc_steer_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int IMM_W       = 16,
  parameter int TGT_W       = 26,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0]  curPc,
  input  logic [XLEN-1:0]  opA,
  input  logic [XLEN-1:0]  opB,
  input  logic [IMM_W-1:0] imm,
  input  logic [TGT_W-1:0] jumpTarget,
  input  pcSel_t           sel,
  output logic             opsDiffer,
  output logic [XLEN-1:0]  nextPc
);
  localparam int ALIGN_SH = $clog2(INSTR_BYTES);
  localparam int REGION_W = XLEN - TGT_W - ALIGN_SH;
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] branchPc;
  logic [XLEN-1:0] jumpPc;

  assign opsDiffer = (opA != opB);
  assign seqPc     = curPc + STEP;
  assign immExt    = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign branchPc  = seqPc + (immExt << ALIGN_SH);

  generate
    if (REGION_W > 0) begin : g_region
      assign jumpPc = {curPc[XLEN-1 -: REGION_W], jumpTarget, {ALIGN_SH{1'b0}}};
    end else begin : g_flat
      assign jumpPc = XLEN'({jumpTarget, {ALIGN_SH{1'b0}}});
    end
  endgenerate

  // AND-OR select; sel is one-hot from the control module.
  always_comb begin
    nextPc = ({XLEN{sel.takeReg}}    & opA)
           | ({XLEN{sel.takeJump}}   & jumpPc)
           | ({XLEN{sel.takeBranch}} & branchPc)
           | ({XLEN{sel.takeSeq}}    & seqPc);
  end

  always_comb begin
    assert_seq_step_R8: assert (!sel.takeSeq || (XLEN'(nextPc - curPc) == STEP))
      else $error("sequential step is not one instruction");
    assert_jump_region_R5: assert (!sel.takeJump ||
        ((nextPc[XLEN-1 -: REGION_W] == curPc[XLEN-1 -: REGION_W]) && (nextPc[ALIGN_SH-1:0] == '0)))
      else $error("direct jump left region or is misaligned");
    assert_branch_needs_differ_R2: assert (!sel.takeBranch || opsDiffer)
      else $error("branch taken on equal operands");
  end
endmodule

// File: rtl/pc_steer.sv
module pc_steer
  import pc_steer_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int IMM_W       = 16,
  parameter int TGT_W       = 26,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0]  curPc,
  input  logic             isBranch,
  input  logic             isJump,
  input  logic             isJumpReg,
  input  logic [XLEN-1:0]  opA,
  input  logic [XLEN-1:0]  opB,
  input  logic [IMM_W-1:0] imm,
  input  logic [TGT_W-1:0] jumpTarget,
  output logic [XLEN-1:0]  nextPc,
  output logic             redirect
);
  pcSel_t sel;
  logic   opsDiffer;

  pc_steer_ctrl u_ctrl (
    .isBranch  (isBranch),
    .isJump    (isJump),
    .isJumpReg (isJumpReg),
    .opsDiffer (opsDiffer),
    .sel       (sel),
    .redirect  (redirect)
  );

  pc_steer_datapath #(
    .XLEN(XLEN), .IMM_W(IMM_W), .TGT_W(TGT_W), .INSTR_BYTES(INSTR_BYTES)
  ) u_dp (
    .curPc      (curPc),
    .opA        (opA),
    .opB        (opB),
    .imm        (imm),
    .jumpTarget (jumpTarget),
    .sel        (sel),
    .opsDiffer  (opsDiffer),
    .nextPc     (nextPc)
  );
endmodule

// File: tb/pc_steer_test.sv
module pc_steer_test;
  logic        clk = 1'b0;
  logic [31:0] curPc = '0, opA = '0, opB = '0;
  logic        isBranch = 1'b0, isJump = 1'b0, isJumpReg = 1'b0;
  logic [15:0] imm = '0;
  logic [25:0] jumpTarget = '0;
  logic [31:0] nextPc;
  logic        redirect;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #5 clk = ~clk;

  pc_steer uut (
    .curPc(curPc), .isBranch(isBranch), .isJump(isJump), .isJumpReg(isJumpReg),
    .opA(opA), .opB(opB), .imm(imm), .jumpTarget(jumpTarget),
    .nextPc(nextPc), .redirect(redirect)
  );

  // Behavioural reference: arithmetic on integers, priority by if-chain.
  function automatic void refModel(output logic [31:0] expPc, output logic expRed);
    longint unsigned seqL;
    longint signed   offL;
    seqL = (longint'(curPc) + 4) % 64'h1_0000_0000;
    offL = longint'($signed(imm)) * 4;
    if (isJumpReg) begin
      expPc = opA; expRed = 1'b1;
    end else if (isJump) begin
      expPc = (curPc & 32'hF000_0000) + 32'(longint'(jumpTarget) * 4); expRed = 1'b1;
    end else if (isBranch && (opA != opB)) begin
      expPc = 32'((longint'(seqL) + offL) & 64'hFFFF_FFFF); expRed = 1'b1;
    end else begin
      expPc = 32'(seqL); expRed = 1'b0;
    end
  endfunction

  task automatic applyVec(input string tag, input logic [31:0] pc, input logic br, input logic jp,
                          input logic jr, input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im, input logic [25:0] tg);
    logic [31:0] expPc;
    logic        expRed;
    @(posedge clk); #1;
    curPc = pc; isBranch = br; isJump = jp; isJumpReg = jr;
    opA = a; opB = b; imm = im; jumpTarget = tg;
    @(negedge clk);
    refModel(expPc, expRed);
    vectors++;
    if (nextPc !== expPc || redirect !== expRed) begin
      misses++;
      $display("FAIL %s: nextPc=%h redirect=%b expected nextPc=%h redirect=%b",
               tag, nextPc, redirect, expPc, expRed);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    // R1 / R9: idle state, sequential step, no redirect
    applyVec("R1", 32'h0040_0000, 0, 0, 0, 0, 0, 16'h0000, 26'h0);
    applyVec("R9", 32'h0000_1000, 0, 0, 0, 32'h5, 32'h6, 16'h7FFF, 26'h3FF_FFFF);
    // R2: taken branch forward
    applyVec("R2", 32'h0040_0010, 1, 0, 0, 32'h1, 32'h2, 16'h0003, 26'h0);
    applyVec("R2", 32'h1000_0000, 1, 0, 0, 32'h8000_0000, 32'h0, 16'h7FFF, 26'h0);
    // R3: equal operands fall through
    applyVec("R3", 32'h0040_0020, 1, 0, 0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'hFFFC, 26'h0);
    // R4: negative offsets
    applyVec("R4", 32'h0040_0040, 1, 0, 0, 32'h0, 32'h1, 16'hFFFC, 26'h0);
    applyVec("R4", 32'h0010_0000, 1, 0, 0, 32'h3, 32'h4, 16'h8000, 26'h0);
    // R5: direct jump keeps the region
    applyVec("R5", 32'hA000_1230, 0, 1, 0, 0, 0, 16'h0, 26'h3FF_FFFF);
    applyVec("R5", 32'h5FFF_FFFC, 0, 1, 0, 0, 0, 16'h0, 26'h000_0001);
    // R6: register jump, unaligned value
    applyVec("R6", 32'h0040_0000, 0, 0, 1, 32'h1234_5679, 32'h0, 16'h0, 26'h0);
    // R7: overlapping flags
    applyVec("R7", 32'h0040_0000, 1, 1, 1, 32'hCAFE_0000, 32'h1, 16'h0004, 26'h123);
    applyVec("R7", 32'h3000_0000, 1, 1, 0, 32'h1, 32'h2, 16'h0004, 26'h123);
    applyVec("R7", 32'h3000_0000, 0, 1, 1, 32'h0BAD_F00D, 32'h2, 16'h0004, 26'h123);
    applyVec("R7", 32'h3000_0000, 1, 0, 1, 32'h7, 32'h7, 16'h0004, 26'h0);
    // R8: wrap at the top of the address space
    applyVec("R8", 32'hFFFF_FFFC, 0, 0, 0, 0, 0, 16'h0, 26'h0);
    applyVec("R8", 32'hFFFF_FFF8, 1, 0, 0, 32'h1, 32'h0, 16'h0004, 26'h0);
    applyVec("R8", 32'h0000_0000, 1, 0, 0, 32'h1, 32'h0, 16'hFFFE, 26'h0);
    // Pseudo-random mix, all requirements (R7 covers flag combinations)
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r1, r2, r3, r4;
      lfsr = step(lfsr); r1 = lfsr;
      lfsr = step(lfsr); r2 = lfsr;
      lfsr = step(lfsr); r3 = lfsr;
      lfsr = step(lfsr); r4 = lfsr;
      applyVec("R7", r1, r4[0], r4[1] & r4[2], r4[3] & r4[4] & r4[5], r2,
               r4[6] ? r2 : r3, r3[15:0], r4[31:6]);
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run hung, expected completion within 5000 cycles");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule